// File: doc/BRIEF.md
# Rotor Cipher Sequencing Engine

This block enciphers one letter at a time, the way an electromechanical rotor machine does. A letter coded 0 to 25 arrives with a strobe while the engine is idle. The engine first advances its rotor positions. It then walks the letter through a fixed schedule of single-cycle steps: a plugboard exchange, a forward pass through three or four rotors, a reflector, a return pass through the same rotors in reverse, and a final plugboard exchange. The result leaves on `out_letter` with a one-cycle `out_valid` strobe.

One shared substitution datapath is reused in every step. A small sequencer selects the operation and the rotor index, so the time per letter grows by four cycles for each configured rotor. The rotor positions load from `init_pos` during reset and then advance once per accepted letter, with notch carries that include the middle-rotor double step. The ring settings on `ring_set` are read live and must stay steady while a letter is in flight. Rotor wirings, the reflector and the plugboard are fixed arithmetic maps rather than stored tables.

Top module: `rotor_cipher_engine`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, `in_ready` is 1 and `out_valid` is 0, and each rotor position register loads its 5-bit field of `init_pos` (rotor k at bits 5k+4..5k, rotor 0 rightmost).
- R2: A letter is taken only in a cycle with `in_valid` and `in_ready` both high. `in_ready` is low from the cycle after acceptance until the cycle that carries `out_valid`. A strobe raised while `in_ready` is low is ignored: it changes neither the result nor the rotor positions.
- R3: With `cfg_long`=0 (three rotors), `out_valid` is high in the 17th cycle when the accepting cycle is counted as cycle 1, that is 15 rising edges after the accepting edge.
- R4: With `cfg_long`=1 (four rotors), `out_valid` is high in the 21st cycle counted the same way, 19 edges after the accepting edge. `cfg_long` is sampled at acceptance.
- R5: `out_valid` is a single-cycle pulse, one per accepted letter.
- R6: On each accepted letter, rotor 0 advances by one before the letter is enciphered, wrapping from 25 to 0. Without an accepted letter, no position changes.
- R7: Advance is decided from the positions before the step. Rotor 1 advances when rotor 0 is at 21 or rotor 1 is at 4. Rotor 2 advances when rotor 1 is at 4, which is the double step. Rotor 3 never advances.
- R8: With offset o_k = (pos_k - ring_k) mod 26, rotor k maps x forward to ((A_k*((x+o_k) mod 26) + 2k+1) mod 26 - o_k) mod 26, with A = 3, 5, 7, 9 for k = 0..3. The return pass applies the inverse wiring in the same frame. The reflector maps x to (x+13) mod 26. The letter passes plugboard, rotors 0 up to N-1, reflector, rotors N-1 down to 0, plugboard.
- R9: The plugboard with the default of six pairs exchanges 2i and 2i+1 for i < 6 and leaves letters 12 to 25 unchanged.
- R10: An enciphered letter never equals its input. From the same starting positions, enciphering the output gives back the input.
- R11: `out_letter` is always below 26 when `out_valid` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low; loads rotor positions |
| cfg_long | input | 1 | 1 selects four rotors, 0 selects three |
| init_pos | input | ROTORS_MAX*LW | Starting position of each rotor, loaded during reset |
| ring_set | input | ROTORS_MAX*LW | Ring setting of each rotor |
| in_valid | input | 1 | Input letter strobe |
| in_letter | input | LW | Letter to encipher, 0 to 25 |
| in_ready | output | 1 | Engine idle, a letter may be taken |
| out_valid | output | 1 | One-cycle strobe with the result |
| out_letter | output | LW | Enciphered letter |

## Verification
The assertions assume that every `in_letter`, `init_pos` field and `ring_set` field lies in 0 to 25. They also assume that `init_pos` is held through reset and that `ring_set` changes only while the engine is idle. The bench drives only letter codes reduced modulo 26, and it changes positions, rings and the rotor count only between letters, with positions loaded under reset. The bench aims its starting positions near the two notches and near the wrap, so that carries, double steps and wraps all occur inside the sweeps.

// File: rtl/rcx_pkg.sv
package rcx_pkg;

   localparam int ALPHA                = 26;
   localparam int MAX_SUPPORTED_ROTORS = 6;
   localparam int HALF_TURN            = 13;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SWAP,
      ST_FADD,
      ST_FMAP,
      ST_REFL,
      ST_BADD,
      ST_BMAP,
      ST_OUT
   } rcx_state_e;

   function automatic int add26(int a, int b);
      int s;
      s = a + b;
      return (s >= ALPHA) ? s - ALPHA : s;
   endfunction

   function automatic int sub26(int a, int b);
      int d;
      d = a - b;
      return (d < 0) ? d + ALPHA : d;
   endfunction

   function automatic int rot_mult(int k);
      case (k)
         0:       return 3;
         1:       return 5;
         2:       return 7;
         3:       return 9;
         4:       return 11;
         default: return 15;
      endcase
   endfunction

   function automatic int rot_mult_inv(int k);
      case (k)
         0:       return 9;
         1:       return 21;
         2:       return 15;
         3:       return 3;
         4:       return 19;
         default: return 7;
      endcase
   endfunction

   function automatic int rot_bias(int k);
      return 2 * k + 1;
   endfunction

   function automatic int wire_fwd(int k, int x);
      return (rot_mult(k) * x + rot_bias(k)) % ALPHA;
   endfunction

   function automatic int wire_inv(int k, int y);
      return (rot_mult_inv(k) * sub26(y, rot_bias(k))) % ALPHA;
   endfunction

   function automatic int reflect26(int x);
      return add26(x, HALF_TURN);
   endfunction

   function automatic int plug_swap(int x, int pairs);
      if (x < 2 * pairs) return x ^ 1;
      return x;
   endfunction

   function automatic int notch_pos(int k);
      return (k == 0) ? 21 : 4;
   endfunction

endpackage

// File: rtl/rcx_stepper.sv
module rcx_stepper
   import rcx_pkg::*;
#(
   parameter int LW         = 5,
   parameter int ROTORS_MAX = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     step_en,
   input  logic [ROTORS_MAX*LW-1:0] init_pos,
   output logic [ROTORS_MAX*LW-1:0] pos
);

   logic [ROTORS_MAX-1:0] advance;
   logic                  at_notch_right;
   logic                  at_notch_mid;

   assign at_notch_right = (int'(pos[LW-1:0])    == notch_pos(0));
   assign at_notch_mid   = (int'(pos[2*LW-1:LW]) == notch_pos(1));

   for (genvar k = 0; k < ROTORS_MAX; k++) begin : g_rot
      logic [LW-1:0] q;

      if (k == 0) begin : g_fast
         assign advance[k] = 1'b1;
      end else if (k == 1) begin : g_mid
         assign advance[k] = at_notch_right | at_notch_mid;
      end else if (k == 2) begin : g_slow
         assign advance[k] = at_notch_mid;
      end else begin : g_fixed
         assign advance[k] = 1'b0;
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            q <= init_pos[k*LW +: LW];
         end else if (step_en && advance[k]) begin
            q <= LW'(add26(int'(q), 1));
         end
      end

      assign pos[k*LW +: LW] = q;
   end

endmodule

// File: rtl/rcx_subst.sv
module rcx_subst
   import rcx_pkg::*;
#(
   parameter int LW         = 5,
   parameter int ROTORS_MAX = 4,
   parameter int PLUG_PAIRS = 6,
   parameter int IW         = 2
) (
   input  rcx_state_e               state,
   input  logic [IW-1:0]            ridx,
   input  logic [LW-1:0]            letter,
   input  logic [ROTORS_MAX*LW-1:0] pos,
   input  logic [ROTORS_MAX*LW-1:0] ring,
   output logic [LW-1:0]            next_letter
);

   logic [LW-1:0] shift_v [ROTORS_MAX];
   logic [LW-1:0] fmap_v  [ROTORS_MAX];
   logic [LW-1:0] bmap_v  [ROTORS_MAX];
   logic [LW-1:0] plug_v;
   logic [LW-1:0] refl_v;

   for (genvar k = 0; k < ROTORS_MAX; k++) begin : g_frame
      logic [LW-1:0] off;
      assign off        = LW'(sub26(int'(pos[k*LW +: LW]), int'(ring[k*LW +: LW])));
      assign shift_v[k] = LW'(add26(int'(letter), int'(off)));
      assign fmap_v[k]  = LW'(sub26(wire_fwd(k, int'(letter)), int'(off)));
      assign bmap_v[k]  = LW'(sub26(wire_inv(k, int'(letter)), int'(off)));
   end

   assign plug_v = LW'(plug_swap(int'(letter), PLUG_PAIRS));
   assign refl_v = LW'(reflect26(int'(letter)));

   always_comb begin
      case (state)
         ST_SWAP: next_letter = plug_v;
         ST_FADD: next_letter = shift_v[ridx];
         ST_FMAP: next_letter = fmap_v[ridx];
         ST_REFL: next_letter = refl_v;
         ST_BADD: next_letter = shift_v[ridx];
         ST_BMAP: next_letter = bmap_v[ridx];
         ST_OUT:  next_letter = plug_v;
         default: next_letter = letter;
      endcase
   end

endmodule

// File: rtl/rcx_seq.sv
module rcx_seq
   import rcx_pkg::*;
#(
   parameter int ROTORS_MAX = 4,
   parameter int IW         = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic          cfg_long,
   output rcx_state_e    state,
   output logic [IW-1:0] ridx,
   output logic          accept
);

   localparam logic [IW-1:0] LAST_SHORT = IW'(ROTORS_MAX - 2);
   localparam logic [IW-1:0] LAST_LONG  = IW'(ROTORS_MAX - 1);

   logic [IW-1:0] last_q;

   assign accept = (state == ST_IDLE) && in_valid;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         ridx   <= '0;
         last_q <= LAST_SHORT;
      end else begin
         case (state)
            ST_IDLE: begin
               if (in_valid) begin
                  state  <= ST_SWAP;
                  last_q <= cfg_long ? LAST_LONG : LAST_SHORT;
               end
            end
            ST_SWAP: begin
               state <= ST_FADD;
               ridx  <= '0;
            end
            ST_FADD: state <= ST_FMAP;
            ST_FMAP: begin
               if (ridx == last_q) begin
                  state <= ST_REFL;
               end else begin
                  ridx  <= ridx + 1'b1;
                  state <= ST_FADD;
               end
            end
            ST_REFL: state <= ST_BADD;
            ST_BADD: state <= ST_BMAP;
            ST_BMAP: begin
               if (ridx == '0) begin
                  state <= ST_OUT;
               end else begin
                  ridx  <= ridx - 1'b1;
                  state <= ST_BADD;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/rotor_cipher_engine.sv
module rotor_cipher_engine
   import rcx_pkg::*;
#(
   parameter int LW         = 5,
   parameter int ROTORS_MAX = 4,
   parameter int PLUG_PAIRS = 6
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cfg_long,
   input  logic [ROTORS_MAX*LW-1:0] init_pos,
   input  logic [ROTORS_MAX*LW-1:0] ring_set,
   input  logic                     in_valid,
   input  logic [LW-1:0]            in_letter,
   output logic                     in_ready,
   output logic                     out_valid,
   output logic [LW-1:0]            out_letter
);

   localparam int IW = $clog2(ROTORS_MAX);

   if ((1 << LW) < ALPHA) begin : g_bad_width
      $error("letter width too narrow for the alphabet");
   end
   if (ROTORS_MAX < 3 || ROTORS_MAX > MAX_SUPPORTED_ROTORS) begin : g_bad_rotors
      $error("rotor count out of supported range");
   end
   if (PLUG_PAIRS < 0 || PLUG_PAIRS > ALPHA / 2) begin : g_bad_pairs
      $error("plugboard pair count out of range");
   end

   rcx_state_e               state;
   logic [IW-1:0]            ridx;
   logic                     accept;
   logic [ROTORS_MAX*LW-1:0] pos_w;
   logic [LW-1:0]            work_q;
   logic [LW-1:0]            next_w;
   logic [LW-1:0]            out_q;
   logic                     done_q;

   rcx_seq #(.ROTORS_MAX(ROTORS_MAX), .IW(IW)) seq_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .cfg_long (cfg_long),
      .state    (state),
      .ridx     (ridx),
      .accept   (accept)
   );

   rcx_stepper #(.LW(LW), .ROTORS_MAX(ROTORS_MAX)) step_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .step_en  (accept),
      .init_pos (init_pos),
      .pos      (pos_w)
   );

   rcx_subst #(.LW(LW), .ROTORS_MAX(ROTORS_MAX), .PLUG_PAIRS(PLUG_PAIRS), .IW(IW)) subst_i (
      .state       (state),
      .ridx        (ridx),
      .letter      (work_q),
      .pos         (pos_w),
      .ring        (ring_set),
      .next_letter (next_w)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         work_q <= '0;
      end else if (accept) begin
         work_q <= in_letter;
      end else if (state != ST_IDLE) begin
         work_q <= next_w;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_q  <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= (state == ST_OUT);
         if (state == ST_OUT) out_q <= next_w;
      end
   end

   assign in_ready   = (state == ST_IDLE);
   assign out_valid  = done_q;
   assign out_letter = out_q;

endmodule

// File: rtl/rcx_checker.sv
module rcx_checker #(
   parameter int LW         = 5,
   parameter int ROTORS_MAX = 4
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     in_valid,
   input logic                     in_ready,
   input logic [LW-1:0]            in_letter,
   input logic                     cfg_long,
   input logic                     out_valid,
   input logic [LW-1:0]            out_letter,
   input logic [ROTORS_MAX*LW-1:0] pos
);

   localparam logic [5:0] LAT_SHORT = 6'(4 * (ROTORS_MAX - 1) + 5);
   localparam logic [5:0] LAT_LONG  = 6'(4 * ROTORS_MAX + 5);

   logic [5:0]    cyc_q;
   logic [LW-1:0] held_in_q;
   logic          held_long_q;
   logic          take;
   logic [LW-1:0] p0, p1, p2;

   assign take = in_valid && in_ready;
   assign p0   = pos[LW-1:0];
   assign p1   = pos[2*LW-1:LW];
   assign p2   = pos[3*LW-1:2*LW];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cyc_q       <= '0;
         held_in_q   <= '0;
         held_long_q <= 1'b0;
      end else if (take) begin
         cyc_q       <= 6'd2;
         held_in_q   <= in_letter;
         held_long_q <= cfg_long;
      end else if (out_valid) begin
         cyc_q <= '0;
      end else if (cyc_q != '0 && cyc_q != 6'h3f) begin
         cyc_q <= cyc_q + 1'b1;
      end
   end

   p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (in_ready && !out_valid));

   p_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_q != '0 && !out_valid) |-> !in_ready);

   p_done_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> in_ready);

   p_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !held_long_q) |-> (cyc_q == LAT_SHORT));

   p_deadline_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!held_long_q && cyc_q == LAT_SHORT) |-> out_valid);

   p_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && held_long_q) |-> (cyc_q == LAT_LONG));

   p_deadline_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (held_long_q && cyc_q == LAT_LONG) |-> out_valid);

   p_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid);

   p_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> (p0 == (($past(p0) == LW'(25)) ? '0 : $past(p0) + 1'b1)));

   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !take |=> $stable(pos));

   p_carry_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (take && p0 == LW'(21)) |=> (p1 != $past(p1)));

   p_double_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (take && p1 == LW'(4)) |=> (p1 != $past(p1) && p2 != $past(p2)));

   if (ROTORS_MAX > 3) begin : g_fixed_chk
      logic [LW-1:0] p3;
      assign p3 = pos[4*LW-1:3*LW];
      p_fixed_r7: assert property (@(posedge clk) disable iff (!rst_n)
         take |=> $stable(p3));
   end

   p_no_fixed_point_r10: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_letter != held_in_q));

   p_out_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_letter < LW'(26)));

endmodule

bind rotor_cipher_engine rcx_checker #(.LW(LW), .ROTORS_MAX(ROTORS_MAX)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .in_ready   (in_ready),
   .in_letter  (in_letter),
   .cfg_long   (cfg_long),
   .out_valid  (out_valid),
   .out_letter (out_letter),
   .pos        (pos_w)
);

// File: tb/rotor_cipher_engine_tb_top.sv
`timescale 1ns/1ps
module rotor_cipher_engine_tb_top;

   logic        clk       = 1'b0;
   logic        rst_n     = 1'b0;
   logic        cfg_long  = 1'b0;
   logic [19:0] init_pos  = '0;
   logic [19:0] ring_set  = '0;
   logic        in_valid  = 1'b0;
   logic [4:0]  in_letter = '0;
   logic        in_ready;
   logic        out_valid;
   logic [4:0]  out_letter;

   int errors   = 0;
   int checks   = 0;
   bit finished = 0;
   int mp [4];
   int mr [4];

   always #2.5 clk = ~clk;

   rotor_cipher_engine dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_long   (cfg_long),
      .init_pos   (init_pos),
      .ring_set   (ring_set),
      .in_valid   (in_valid),
      .in_ready   (in_ready),
      .in_letter  (in_letter),
      .out_valid  (out_valid),
      .out_letter (out_letter)
   );

   task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int m_mult(int k);
      int t [4] = '{3, 5, 7, 9};
      return t[k];
   endfunction

   function automatic int m_inv(int k);
      int t [4] = '{9, 21, 15, 3};
      return t[k];
   endfunction

   function automatic int m_plug(int x);
      return (x < 12) ? (x ^ 1) : x;
   endfunction

   function automatic void m_step();
      bit c1, c2;
      c1 = (mp[0] == 21) || (mp[1] == 4);
      c2 = (mp[1] == 4);
      mp[0] = (mp[0] + 1) % 26;
      if (c1) mp[1] = (mp[1] + 1) % 26;
      if (c2) mp[2] = (mp[2] + 1) % 26;
   endfunction

   function automatic int m_enc(int x, int nrot);
      int y, o;
      y = m_plug(x);
      for (int k = 0; k < nrot; k++) begin
         o = (mp[k] - mr[k] + 26) % 26;
         y = (y + o) % 26;
         y = (m_mult(k) * y + 2 * k + 1) % 26;
         y = (y - o + 26) % 26;
      end
      y = (y + 13) % 26;
      for (int k = nrot - 1; k >= 0; k--) begin
         o = (mp[k] - mr[k] + 26) % 26;
         y = (y + o) % 26;
         y = (m_inv(k) * ((y - (2 * k + 1) + 26) % 26)) % 26;
         y = (y - o + 26) % 26;
      end
      return m_plug(y);
   endfunction

   task automatic do_reset(input int p0, input int p1, input int p2, input int p3,
                           input int r0, input int r1, input int r2, input int r3);
      @(negedge clk);
      rst_n    = 1'b0;
      init_pos = {5'(p3), 5'(p2), 5'(p1), 5'(p0)};
      ring_set = {5'(r3), 5'(r2), 5'(r1), 5'(r0)};
      mp[0] = p0; mp[1] = p1; mp[2] = p2; mp[3] = p3;
      mr[0] = r0; mr[1] = r1; mr[2] = r2; mr[3] = r3;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic send(input int x, input bit inject, input string tag, output int y);
      int n, nrot, expv, lat;
      bit seen, busy_ok;
      nrot = cfg_long ? 4 : 3;
      lat  = 4 * nrot + 3;
      m_step();
      expv = m_enc(x, nrot);
      @(negedge clk);
      check(in_ready == 1'b1, "R2", "ready while idle", int'(in_ready), 1);
      in_letter = 5'(x);
      in_valid  = 1'b1;
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      n = 0; seen = 0; busy_ok = 1;
      while (!seen && n < 60) begin
         if (inject && n == 4) begin
            in_valid  = 1'b1;
            in_letter = 5'((x + 9) % 26);
         end else begin
            in_valid = 1'b0;
         end
         @(posedge clk);
         n++;
         @(negedge clk);
         if (out_valid) seen = 1;
         else if (in_ready) busy_ok = 0;
      end
      in_valid = 1'b0;
      check(busy_ok, "R2", "ready low while busy", int'(busy_ok), 1);
      check(n == lat, (nrot == 4) ? "R4" : "R3", "edges to done", n, lat);
      y = int'(out_letter);
      check(y == expv, tag, "enciphered letter", y, expv);
      check(y != x, "R10", "no fixed point", y, x + 100);
      check(y < 26, "R11", "output range", y, 25);
      @(posedge clk);
      @(negedge clk);
      check(out_valid == 1'b0, "R5", "single-cycle done", int'(out_valid), 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int y, z;
      do_reset(0, 0, 0, 0, 0, 0, 0, 0);
      check(in_ready == 1'b1, "R1", "ready after reset", int'(in_ready), 1);
      check(out_valid == 1'b0, "R1", "no done after reset", int'(out_valid), 0);

      // R1 R8 R9: full three-rotor sweep from loaded positions
      cfg_long = 1'b0;
      for (int x = 0; x < 26; x++) send(x, 1'b0, "R1 R8 R9", y);

      // R10: reciprocity from identical starting positions
      for (int t = 0; t < 6; t++) begin
         do_reset(t * 5, t * 3, t, 0, 2, 5, 1, 0);
         send(t * 4, 1'b0, "R8", y);
         do_reset(t * 5, t * 3, t, 0, 2, 5, 1, 0);
         send(y, 1'b0, "R8", z);
         check(z == t * 4, "R10", "reciprocal", z, t * 4);
      end

      // R6 R7: carries, double step and wrap of the fast rotor
      do_reset(20, 3, 0, 9, 1, 2, 3, 4);
      for (int i = 0; i < 32; i++) send((i * 7) % 26, 1'b0, "R6 R7 R8", y);

      // R4 R7: four rotors, rotor 3 stationary, double step on first letter
      cfg_long = 1'b1;
      do_reset(3, 4, 25, 11, 0, 7, 2, 5);
      for (int x = 0; x < 26; x++) send(x, 1'b0, "R4 R7 R8 R9", y);

      // R2: strobe while busy is ignored, next letter sees one step only
      cfg_long = 1'b0;
      do_reset(24, 21, 4, 0, 3, 0, 6, 0);
      send(5, 1'b1, "R2 R8", y);
      send(6, 1'b0, "R2 R6", y);
      send(17, 1'b1, "R2 R8", y);

      // R3 R4: rotor count switched between letters
      for (int i = 0; i < 10; i++) begin
         cfg_long = i[0];
         send((i * 11 + 3) % 26, 1'b0, "R3 R4 R8", y);
      end

      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule